// File: doc/BRIEF.md
# Escape-Aware Virtual Channel Allocator

This block assigns output virtual channels to input virtual channels inside a four-port router that carries four virtual channels per port. On every port the top channel (VC 3) is the escape channel; VCs 0 to 2 are normal channels. Each input VC that holds a routed head flit presents a request, an adaptive port mask, a deterministic port and a class bit. A request is granted in the same cycle it is presented. A granted output VC stays reserved until a tail-flit release arrives for it.

Allocation runs in two stages and is input-first and separable. In the first stage each input VC picks one free candidate output VC. Normal candidates on the adaptive ports win over the escape VC on the deterministic port. Among candidates of the winning class, the pick is the first output VC index found when scanning upward, with wrap, from the input's own index. In the second stage each output VC has a matrix arbiter over all input VCs. The arbiter grants one requester and then moves that requester to the lowest priority. The rules for the escape channel are applied in the first stage. Injected packets never reach an escape VC. A packet already on an escape VC stays on the escape VC of its deterministic port.

Top module: `escape_vc_alloc`

## Requirements
- R1: After reset every output VC is free. No grant is issued while no request is raised. Each output arbiter starts in fixed order, with a lower input index beating a higher one.
- R2: An input VC on port 0, the injection port, is never granted an output VC whose VC field (index modulo 4) equals 3. This holds regardless of its class bit.
- R3: An input VC on a non-injection port whose class bit is 1 can be granted only output VC `4*det_port+3`.
- R4: An input VC with class bit 0 can be granted either a VC 0..2 on a port whose bit is set in its adaptive mask, or VC 3 of its deterministic port.
- R5: When at least one permitted normal output VC is free, the input VC gets a normal VC, even if its permitted escape VC is also free.
- R6: Only a free output VC is granted. Once granted, it reads busy (`ovc_free` low) from the next cycle until the cycle after its `ovc_release` bit is high.
- R7: In any cycle, at most one output VC is granted per input VC, and each output VC is granted to at most one input VC. A grant is only given to a requesting input.
- R8: After an output VC grants input `a`, every other input VC beats `a` in that output's arbiter.
- R9: An input VC `i` picks, from the free candidates of its preferred class, the one with the smallest cyclic distance `(o - i) mod 16` upward from `i`. The output VC index is `o = 4*port + vc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 16 | Bit `i`: input VC `i` requests an output VC |
| req_esc | input | 16 | Bit `i`: input VC `i` already travels on the escape class |
| adapt_mask | input | 64 | Bits `[4i+3:4i]`: output ports allowed for normal VCs of input `i`, where bit `q` means port `q` |
| det_port | input | 32 | Bits `[2i+1:2i]`: deterministic output port of input `i` |
| ovc_release | input | 16 | Bit `o`: tail flit leaves output VC `o`, so it is freed |
| gnt | output | 16 | Bit `i`: input VC `i` is granted this cycle |
| gnt_ovc | output | 64 | Bits `[4i+3:4i]`: output VC index granted to input `i`, zero when not granted |
| ovc_free | output | 16 | Bit `o`: output VC `o` is free |

## Verification
The bench targets four corner cases.
- An injection-port packet whose normal VCs are all busy while the escape VC is free must get no grant. A design that leaks the escape VC to injected traffic would grant VC 3.
- An escape-class packet with a full adaptive mask must still land on the escape VC of its deterministic port. A wrong design would wander onto normal VCs.
- An input whose cyclic scan meets the escape VC before any normal VC must still take the normal one. A design that only scans would pick the escape VC first.
- Two inputs contend for the same output across a release. The first winner must lose the second round. A fixed-priority design, or one that drops the busy mark, would grant the same input twice or double-book a VC.

// File: rtl/escape_vc_alloc.sv
module escape_vc_alloc #(
  parameter int NPORT = 4,
  parameter int NVC   = 4,
  parameter int INJ   = 0
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [NPORT*NVC-1:0]                          req,
  input  logic [NPORT*NVC-1:0]                          req_esc,
  input  logic [NPORT*NVC*NPORT-1:0]                    adapt_mask,
  input  logic [NPORT*NVC*$clog2(NPORT)-1:0]            det_port,
  input  logic [NPORT*NVC-1:0]                          ovc_release,
  output logic [NPORT*NVC-1:0]                          gnt,
  output logic [NPORT*NVC*$clog2(NPORT*NVC)-1:0]        gnt_ovc,
  output logic [NPORT*NVC-1:0]                          ovc_free
);
  localparam int NIN  = NPORT * NVC;
  localparam int PW   = $clog2(NPORT);
  localparam int OW   = $clog2(NIN);
  localparam int ESC  = NVC - 1;
  localparam int NTRI = NIN * (NIN - 1) / 2;

  logic [NTRI-1:0] mtx    [NIN];
  logic [NIN-1:0]  busy;
  logic [NIN-1:0]  el_n   [NIN];
  logic [NIN-1:0]  el_e   [NIN];
  logic [NIN-1:0]  sel    [NIN];
  logic [OW-1:0]   pick   [NIN];
  logic [NIN-1:0]  pick_v;
  logic [NIN-1:0]  win    [NIN];

  function automatic int tri_idx(int a, int b);
    return a * NIN - (a * (a + 1)) / 2 + b - a - 1;
  endfunction

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      for (int o = 0; o < NIN; o++) begin
        el_n[i][o] = req[i] && !(req_esc[i] && (i / NVC != INJ)) && (o % NVC != ESC)
                     && adapt_mask[i*NPORT + o/NVC] && !busy[o];
        el_e[i][o] = req[i] && (i / NVC != INJ) && (o % NVC == ESC)
                     && (int'(det_port[i*PW +: PW]) == o / NVC) && !busy[o];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      sel[i]    = (|el_n[i]) ? el_n[i] : el_e[i];
      pick_v[i] = |sel[i];
      pick[i]   = '0;
      for (int k = NIN - 1; k >= 0; k--)
        if (sel[i][(i + k) % NIN]) pick[i] = OW'((i + k) % NIN);
    end
  end

  always_comb begin
    for (int o = 0; o < NIN; o++) begin
      for (int a = 0; a < NIN; a++) begin
        win[o][a] = pick_v[a] && (pick[a] == OW'(o));
        for (int b = 0; b < NIN; b++) begin
          if (b != a && pick_v[b] && pick[b] == OW'(o)) begin
            if (a < b) win[o][a] = win[o][a] && mtx[o][tri_idx(a, b)];
            else       win[o][a] = win[o][a] && !mtx[o][tri_idx(b, a)];
          end
        end
      end
    end
  end

  always_comb begin
    for (int a = 0; a < NIN; a++) begin
      gnt[a] = 1'b0;
      for (int o = 0; o < NIN; o++) gnt[a] = gnt[a] | win[o][a];
      gnt_ovc[a*OW +: OW] = gnt[a] ? pick[a] : '0;
    end
  end

  assign ovc_free = ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      for (int o = 0; o < NIN; o++) mtx[o] <= '1;
    end else begin
      for (int o = 0; o < NIN; o++) begin
        busy[o] <= (busy[o] & ~ovc_release[o]) | (|win[o]);
        for (int a = 0; a < NIN; a++)
          for (int b = a + 1; b < NIN; b++) begin
            if (win[o][a])      mtx[o][tri_idx(a, b)] <= 1'b0;
            else if (win[o][b]) mtx[o][tri_idx(a, b)] <= 1'b1;
          end
      end
    end
  end

  logic [NIN-1:0] tgt [NIN];
  always_comb begin
    for (int o = 0; o < NIN; o++)
      for (int a = 0; a < NIN; a++)
        tgt[o][a] = gnt[a] && (gnt_ovc[a*OW +: OW] == OW'(o));
  end

  generate
    for (genvar a = 0; a < NIN; a++) begin : g_chk_in
      AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[a] |-> req[a]);                                                  // R7
      AST_GNT_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[a] |-> ovc_free[gnt_ovc[a*OW +: OW]]);                           // R6
      AST_BUSY_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[a] |=> !ovc_free[$past(gnt_ovc[a*OW +: OW])]);                   // R6
      if (a / NVC == INJ) begin : g_inj
        AST_INJ_NO_ESC: assert property (@(posedge clk) disable iff (!rst_n)
          gnt[a] |-> (int'(gnt_ovc[a*OW +: OW]) % NVC != ESC));              // R2
      end else begin : g_net
        AST_ESC_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
          (gnt[a] && req_esc[a]) |->
          (int'(gnt_ovc[a*OW +: OW]) == int'(det_port[a*PW +: PW]) * NVC + ESC)); // R3
      end
    end
    for (genvar o = 0; o < NIN; o++) begin : g_chk_out
      AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt[o]));                                                   // R7
      AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (ovc_release[o] && !ovc_free[o]) |=> ovc_free[o]);                   // R6
    end
  endgenerate
endmodule

// File: tb/test_escape_vc_alloc.sv
module test_escape_vc_alloc;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0, req_esc = '0, rel = '0;
  logic [63:0] mask = '0;
  logic [31:0] det = '0;
  logic [15:0] gnt, ovc_free;
  logic [63:0] gnt_ovc;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  int busy_m [N];
  int ord [N][$];
  int exp_g [N];
  int exp_o [N];

  always #4 clk = ~clk;

  escape_vc_alloc i_escape_vc_alloc (
    .clk(clk), .rst_n(rst_n), .req(req), .req_esc(req_esc), .adapt_mask(mask),
    .det_port(det), .ovc_release(rel), .gnt(gnt), .gnt_ovc(gnt_ovc), .ovc_free(ovc_free));

  task automatic model_reset();
    for (int o = 0; o < N; o++) begin
      busy_m[o] = 0;
      ord[o].delete();
      for (int a = 0; a < N; a++) ord[o].push_back(a);
    end
  endtask

  function automatic bit may_use(int i, int o, bit normal);
    int ip = i / 4, op = o / 4, ov = o % 4;
    if (!req[i] || busy_m[o] != 0) return 0;
    if (normal) return (ov != 3) && mask[i*4+op] && !(req_esc[i] && ip != 0);
    return (ov == 3) && (ip != 0) && (int'(det[i*2 +: 2]) == op);
  endfunction

  task automatic model_eval();
    int want [N];
    for (int i = 0; i < N; i++) begin
      want[i] = -1;
      for (int k = 0; k < N && want[i] < 0; k++)
        if (may_use(i, (i + k) % N, 1)) want[i] = (i + k) % N;
      for (int k = 0; k < N && want[i] < 0; k++)
        if (may_use(i, (i + k) % N, 0)) want[i] = (i + k) % N;
      exp_g[i] = 0;
      exp_o[i] = 0;
    end
    for (int o = 0; o < N; o++)
      foreach (ord[o][p]) begin
        if (want[ord[o][p]] == o) begin
          exp_g[ord[o][p]] = 1;
          exp_o[ord[o][p]] = o;
          break;
        end
      end
  endtask

  task automatic model_clock();
    for (int o = 0; o < N; o++) if (rel[o]) busy_m[o] = 0;
    for (int a = 0; a < N; a++)
      if (exp_g[a] == 1) begin
        int o = exp_o[a];
        busy_m[o] = 1;
        foreach (ord[o][p]) if (ord[o][p] == a) begin ord[o].delete(p); break; end
        ord[o].push_back(a);
      end
  endtask

  task automatic check(string tag, int act, int exp, string what);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    #1;
    model_eval();
    for (int i = 0; i < N; i++) begin
      check(tag, int'(gnt[i]), exp_g[i], $sformatf("gnt[%0d]", i));
      if (exp_g[i] == 1) check(tag, int'(gnt_ovc[i*4 +: 4]), exp_o[i], $sformatf("gnt_ovc[%0d]", i));
    end
    for (int o = 0; o < N; o++)
      check(tag, int'(ovc_free[o]), busy_m[o] == 0 ? 1 : 0, $sformatf("ovc_free[%0d]", o));
    @(posedge clk);
    model_clock();
    @(negedge clk);
  endtask

  task automatic clear_in();
    req = '0; req_esc = '0; mask = '0; det = '0; rel = '0;
  endtask

  task automatic set_in(int i, bit esc, logic [3:0] m, logic [1:0] d);
    req[i] = 1'b1; req_esc[i] = esc; mask[i*4 +: 4] = m; det[i*2 +: 2] = d;
  endtask

  task automatic free_all();
    clear_in(); rel = '1; step("R6"); rel = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1");

    set_in(6, 0, 4'b1111, 0); step("R9");
    clear_in(); step("R6");
    rel[6] = 1'b1; step("R6"); rel = '0; step("R6");

    set_in(4, 0, 4'b0100, 0); set_in(5, 0, 4'b0100, 0); step("R1");
    clear_in(); rel[8] = 1'b1; step("R6"); rel = '0;
    set_in(4, 0, 4'b0100, 0); set_in(5, 0, 4'b0100, 0); step("R8");
    free_all();

    set_in(7, 0, 4'b0010, 1); step("R5");
    free_all();

    set_in(8, 0, 4'b0010, 0);
    repeat (3) step("R4");
    clear_in(); set_in(1, 1, 4'b0010, 1); step("R2");
    clear_in(); set_in(2, 0, 4'b0010, 1); step("R2");
    clear_in(); set_in(13, 0, 4'b0010, 1); step("R4");
    clear_in(); set_in(11, 1, 4'b1111, 3); step("R3");
    clear_in(); set_in(12, 1, 4'b1111, 3); step("R3");
    free_all();

    for (int c = 0; c < 400; c++) begin
      clear_in();
      for (int i = 0; i < N; i++)
        if ($urandom_range(0, 1) == 1)
          set_in(i, 1'($urandom_range(0, 3) == 0), 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)));
      for (int o = 0; o < N; o++) rel[o] = ($urandom_range(0, 3) == 0);
      step("R7");
    end
    finish_run();
  end
endmodule